// File: doc/BRIEF.md
# Instruction Prefetch Queue with Jump Folding

This block sits between instruction memory and decode. It reads instruction words ahead of demand and keeps them in a small circular queue. Decode drains the queue through a ready/valid port, and each word arrives with the byte address it was read from. Reads go out on a request port that is always accepted. Memory answers on a response port in request order, after any latency.

The block inspects every returned word. An unconditional jump is consumed inside the fetch unit and never delivered. Fetching moves to the jump's target, so decode sees the target instructions next with no stall slot. Any reads already issued down the fall-through path are discarded as they return.

Conditional control flow is left to the execute stage. That stage sends a redirect carrying the corrected address. The redirect empties the queue, discards every outstanding read, and restarts fetching at that address on the following cycle.

Top module: `pfq_fetch`

## Requirements
- R1: While reset is held (synchronous, active high), `dq_valid` is 0, `req_valid` is 1 and `req_addr` equals `BOOT_ADDR` (default 16'h0100).
- R2: Words that are not jumps are delivered in program order. Addresses advance by 4. Each delivery carries the word read from memory and the byte address it came from.
- R3: The queue holds up to `DEPTH` (8) words. An offered word and its address stay stable until accepted. A dequeue in the same cycle as an enqueue loses and duplicates nothing.
- R4: A request is issued only while free queue slots outnumber live outstanding reads, and total outstanding reads stay below `MAX_INFL`. With decode stalled from reset, exactly `DEPTH` requests are issued.
- R5: A word whose bits [31:26] equal 6'b000010 is an unconditional jump to (its address + 4 * bits[25:0]) mod 2^AW. It is never delivered. The next word delivered is the one at the target, and chains of jumps are followed.
- R6: When a jump word is captured and the queue has room, the request for the jump target is issued in the very next cycle.
- R7: A redirect empties the queue and discards every read already outstanding. In the next cycle `req_addr` is the redirect address, and delivery resumes with the word at that address.
- R8: A redirect takes priority over a jump captured in the same cycle.
- R9: Outstanding reads never exceed `MAX_INFL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | output | 1 | Read request, accepted whenever asserted |
| req_addr | output | AW | Byte address of the read |
| resp_valid | input | 1 | Read data returned, in request order |
| resp_data | input | DW | Returned instruction word |
| redir_valid | input | 1 | Redirect from execute |
| redir_addr | input | AW | Redirect target address |
| dq_valid | output | 1 | Queue head valid toward decode |
| dq_ready | input | 1 | Decode accepts the head |
| dq_addr | output | AW | Address of the head word |
| dq_instr | output | DW | Head instruction word |

## Verification
The two functions that can meet in one cycle are jump folding and an external redirect. The collision happens when a jump word returns from memory in the same cycle that execute redirects. The bench places a jump early in the program and sweeps the redirect across a range of cycle offsets after reset, so that one offset lands exactly on the jump's return. Every case is judged by the delivered stream. It must restart at the redirect address and contain no word from the jump target.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int OPC_MSB = 31;
    localparam int OPC_LSB = 26;
    localparam logic [OPC_MSB-OPC_LSB:0] OPC_JUMP = 6'b000010;

    function automatic logic opc_is_jump(input logic [OPC_MSB-OPC_LSB:0] opc);
        return opc == OPC_JUMP;
    endfunction
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
    parameter int W     = 48,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t r_q, r_d;
    logic [W-1:0] slots [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        r_d     = r_q;
        do_push = push && !flush && (r_q.cnt != CW'(DEPTH));
        do_pop  = pop && !flush && (r_q.cnt != '0);
        if (flush) begin
            r_d = '0;
        end else begin
            if (do_push) r_d.tail = r_q.tail + 1'b1;
            if (do_pop)  r_d.head = r_q.head + 1'b1;
            r_d.cnt = r_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[r_q.tail] <= push_data;
    end

    assign head_data = slots[r_q.head];
    assign count     = r_q.cnt;
endmodule

// File: rtl/pfq_jump.sv
module pfq_jump #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic [DW-1:0] instr,
    input  logic [AW-1:0] addr,
    output logic          is_jump,
    output logic [AW-1:0] target
);
    import pfq_pkg::*;

    // offset is a signed word count; truncating to AW-2 bits keeps the
    // sum correct modulo 2^AW
    always_comb begin
        is_jump = opc_is_jump(instr[OPC_MSB:OPC_LSB]);
        target  = addr + {instr[AW-3:0], 2'b00};
    end
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
    parameter int          AW        = 16,
    parameter int          DW        = 32,
    parameter int          DEPTH     = 8,
    parameter int          MAX_INFL  = 8,
    parameter logic [15:0] BOOT_ADDR = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    input  logic          resp_valid,
    input  logic [DW-1:0] resp_data,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    output logic          dq_valid,
    input  logic          dq_ready,
    output logic [AW-1:0] dq_addr,
    output logic [DW-1:0] dq_instr
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int KW = $clog2(DEPTH+MAX_INFL+1);
    localparam int EW = AW + DW;

    typedef struct packed {
        logic [AW-1:0] pc;    // next request address
        logic [AW-1:0] rpc;   // address of next live response
        logic [KW-1:0] live;  // outstanding reads on the current path
        logic [KW-1:0] drop;  // outstanding reads to be discarded
    } fetch_t;

    fetch_t s_q, s_d;

    logic [CW-1:0] q_cnt;
    logic [EW-1:0] q_head;
    logic [KW-1:0] free_slots, live_n, drop_n;
    logic          issue, resp_live, resp_drop, push, pop;
    logic          j_hit;
    logic [AW-1:0] j_tgt;

    pfq_jump #(.AW(AW), .DW(DW)) jump_i (
        .instr   (resp_data),
        .addr    (s_q.rpc),
        .is_jump (j_hit),
        .target  (j_tgt)
    );

    always_comb begin
        s_d        = s_q;
        free_slots = KW'(DEPTH) - KW'(q_cnt);
        issue      = (free_slots > s_q.live) &&
                     ((s_q.live + s_q.drop) < KW'(MAX_INFL));
        resp_drop  = resp_valid && (s_q.drop != '0);
        resp_live  = resp_valid && (s_q.drop == '0);
        push       = resp_live && !j_hit && !redir_valid;
        pop        = (q_cnt != '0) && dq_ready;
        live_n     = s_q.live + KW'(issue) - KW'(resp_live);
        drop_n     = s_q.drop - KW'(resp_drop);

        if (redir_valid) begin
            s_d.drop = drop_n + live_n;
            s_d.live = '0;
            s_d.pc   = redir_addr;
            s_d.rpc  = redir_addr;
        end else if (resp_live && j_hit) begin
            s_d.drop = drop_n + live_n;
            s_d.live = '0;
            s_d.pc   = j_tgt;
            s_d.rpc  = j_tgt;
        end else begin
            s_d.drop = drop_n;
            s_d.live = live_n;
            if (issue)     s_d.pc  = s_q.pc + AW'(4);
            if (resp_live) s_d.rpc = s_q.rpc + AW'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.pc   <= AW'(BOOT_ADDR);
            s_q.rpc  <= AW'(BOOT_ADDR);
        end else begin
            s_q <= s_d;
        end
    end

    pfq_ring #(.W(EW), .DEPTH(DEPTH)) ring_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .push      (push),
        .push_data ({s_q.rpc, resp_data}),
        .pop       (pop),
        .head_data (q_head),
        .count     (q_cnt)
    );

    assign req_valid = issue;
    assign req_addr  = s_q.pc;
    assign dq_valid  = q_cnt != '0;
    assign dq_addr   = q_head[EW-1:DW];
    assign dq_instr  = q_head[DW-1:0];
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int          AW        = 16,
    parameter int          DW        = 32,
    parameter int          DEPTH     = 8,
    parameter int          MAX_INFL  = 8,
    parameter logic [15:0] BOOT_ADDR = 16'h0100
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          resp_valid,
    input logic [DW-1:0] resp_data,
    input logic          redir_valid,
    input logic [AW-1:0] redir_addr,
    input logic          dq_valid,
    input logic          dq_ready,
    input logic [AW-1:0] dq_addr,
    input logic [DW-1:0] dq_instr
);
    import pfq_pkg::*;
    localparam int KW = $clog2(DEPTH+MAX_INFL+1) + 1;

    logic [KW-1:0] infl_q;
    always_ff @(posedge clk) begin
        if (rst) infl_q <= '0;
        else     infl_q <= infl_q + KW'(req_valid) - KW'(resp_valid);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> !dq_valid && req_valid && req_addr == AW'(BOOT_ADDR));

    assert_head_hold_R3: assert property (@(posedge clk) disable iff (rst)
        dq_valid && !dq_ready && !redir_valid |=>
            dq_valid && $stable(dq_addr) && $stable(dq_instr));

    assert_no_jump_out_R5: assert property (@(posedge clk) disable iff (rst)
        dq_valid |-> !opc_is_jump(dq_instr[OPC_MSB:OPC_LSB]));

    assert_redirect_flush_R7: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !dq_valid && req_addr == $past(redir_addr));

    assert_infl_bound_R9: assert property (@(posedge clk) disable iff (rst)
        infl_q <= KW'(MAX_INFL));
endmodule

bind pfq_fetch pfq_checker #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .MAX_INFL(MAX_INFL), .BOOT_ADDR(BOOT_ADDR)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .dq_valid(dq_valid), .dq_ready(dq_ready),
    .dq_addr(dq_addr), .dq_instr(dq_instr)
);

// File: tb/pfq_fetch_tb_top.sv
module pfq_fetch_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [15:0] BOOT = 16'h0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          resp_valid = 1'b0;
    logic [DW-1:0] resp_data = '0;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_addr = '0;
    logic          dq_valid;
    logic          dq_ready = 1'b0;
    logic [AW-1:0] dq_addr;
    logic [DW-1:0] dq_instr;

    always #4 clk = ~clk;

    pfq_fetch dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .dq_valid(dq_valid), .dq_ready(dq_ready),
        .dq_addr(dq_addr), .dq_instr(dq_instr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // program image: jump table plus a sequential filler word
    logic [15:0] jsrc [4];
    logic [25:0] joff [4];
    bit          jen  [4];

    function automatic logic [31:0] prog(input logic [15:0] a);
        for (int i = 0; i < 4; i++)
            if (jen[i] && jsrc[i] == a) return {6'b000010, joff[i]};
        return {6'b000001, 10'h000, a};
    endfunction

    function automatic logic [15:0] follow(input logic [15:0] a);
        logic [15:0] x = a;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w = prog(x);
            if (w[31:26] == 6'b000010) x = x + {w[13:0], 2'b00};
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model
    int  lat = 1;
    bit  pv [4];
    logic [15:0] pa [4];
    int  req_cnt = 0;
    bit  chk_fold = 0;
    bit  fold_pend = 0;
    logic [15:0] fold_tgt;

    initial forever begin
        @(negedge clk);
        if (rst) begin
            for (int i = 0; i < 4; i++) pv[i] = 0;
            resp_valid = 0;
            fold_pend  = 0;
        end else begin
            if (fold_pend) begin
                // R6: target request in the cycle after the jump is captured
                chk(req_valid && req_addr == fold_tgt, "R6",
                    {15'h0, req_valid, req_addr}, {16'h0001, fold_tgt});
                fold_pend = 0;
            end
            resp_valid = pv[lat-1];
            resp_data  = prog(pa[lat-1]);
            if (chk_fold && resp_valid && resp_data[31:26] == 6'b000010) begin
                fold_pend = 1;
                fold_tgt  = pa[lat-1] + {resp_data[13:0], 2'b00};
            end
            for (int i = 3; i > 0; i--) begin
                pv[i] = pv[i-1];
                pa[i] = pa[i-1];
            end
            pv[0] = req_valid;
            pa[0] = req_addr;
            if (req_valid) req_cnt++;
        end
    end

    // decode side: ready pattern, redirect driving, stream compare
    int          rmode = 0;
    int          cyc = 0;
    int          got = 0;
    logic [15:0] exp_a;
    bit          redir_pend = 0;
    logic [15:0] redir_tgt;

    initial forever begin
        @(negedge clk);
        cyc++;
        if (rst) begin
            dq_ready    = 0;
            redir_valid = 0;
        end else begin
            case (rmode)
                0: dq_ready = 1;
                1: dq_ready = 0;
                2: dq_ready = cyc[0];
                default: dq_ready = (cyc % 3) == 0;
            endcase
            if (redir_pend) begin
                redir_valid = 1;
                redir_addr  = redir_tgt;
                exp_a       = follow(redir_tgt);
                redir_pend  = 0;
            end else begin
                redir_valid = 0;
                if (dq_valid && dq_ready) begin
                    // R2 order and contents; R5 jumps never appear
                    chk(dq_addr == exp_a && dq_instr == prog(exp_a), "R2/R5",
                        {dq_addr, dq_instr[15:0]}, {exp_a, prog(exp_a)[15:0]});
                    exp_a = follow(exp_a + 16'd4);
                    got++;
                end
            end
        end
    end

    task automatic do_reset(input int l, input int mode);
        @(posedge clk); #1 rst = 1;
        lat = l; rmode = mode; got = 0; exp_a = follow(BOOT);
        repeat (3) @(posedge clk);
        #1 rst = 0;
        req_cnt = 0;
    endtask

    task automatic wait_got(input int n);
        while (got < n) @(posedge clk);
    endtask

    task automatic redirect(input logic [15:0] a);
        redir_tgt  = a;
        redir_pend = 1;
        do @(posedge clk); while (redir_pend);
        @(negedge clk);
        chk(req_addr == a, "R7", {16'h0, req_addr}, {16'h0, a});
    endtask

    task automatic clear_jumps();
        for (int i = 0; i < 4; i++) jen[i] = 0;
        chk_fold = 0;
    endtask

    task automatic t_reset();
        clear_jumps();
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!dq_valid, "R1", {31'h0, dq_valid}, 32'h0);
        chk(req_valid, "R1", {31'h0, req_valid}, 32'h1);
        chk(req_addr == BOOT, "R1", {16'h0, req_addr}, {16'h0, BOOT});
    endtask

    task automatic t_sequential();
        clear_jumps();
        do_reset(2, 2);
        wait_got(20);
        do_reset(1, 0);
        wait_got(20);
    endtask

    task automatic t_fill();
        clear_jumps();
        do_reset(3, 1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        // R4: stalled decode lets exactly DEPTH requests out
        chk(req_cnt == 8, "R4", req_cnt, 8);
        chk(dq_valid, "R3", {31'h0, dq_valid}, 32'h1);
        chk(dq_addr == BOOT, "R3", {16'h0, dq_addr}, {16'h0, BOOT});
        rmode = 0;
        wait_got(16);
    endtask

    task automatic t_fold();
        clear_jumps();
        jsrc[0] = 16'h0108; joff[0] = 26'd16;          jen[0] = 1;  // -> 0x0148
        jsrc[1] = 16'h0150; joff[1] = 26'h3FFFFEC;     jen[1] = 1;  // -> 0x0100
        chk_fold = 1;
        do_reset(1, 0);
        wait_got(24);
        chk_fold = 0;
        // chained jumps under longer latency and slow decode
        clear_jumps();
        jsrc[0] = 16'h0104; joff[0] = 26'd4; jen[0] = 1;            // -> 0x0114
        jsrc[1] = 16'h0114; joff[1] = 26'd8; jen[1] = 1;            // -> 0x0134
        do_reset(3, 3);
        wait_got(12);
    endtask

    task automatic t_redirect();
        clear_jumps();
        do_reset(3, 0);
        wait_got(10);
        redirect(16'h0400);
        got = 0;
        wait_got(10);
        rmode = 1;
        repeat (20) @(posedge clk);
        redirect(16'h0800);
        rmode = 2;
        got = 0;
        wait_got(10);
    endtask

    task automatic t_collide();
        // R8: redirect swept across the cycle where the jump returns
        for (int k = 0; k < 10; k++) begin
            clear_jumps();
            jsrc[0] = 16'h0110; joff[0] = 26'd60; jen[0] = 1;       // -> 0x0200
            do_reset(2, 0);
            repeat (k + 2) @(posedge clk);
            redirect(16'h0600);
            got = 0;
            wait_got(6);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sequential();
        t_fill();
        t_fold();
        t_redirect();
        t_collide();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule